// File: doc/BRIEF.md
# Per-CPU Interrupt Wakeup Generator

This block sits in an always-on power domain, between the shared peripheral interrupt lines and the downstream interrupt distributor. Each line reaches the distributor unchanged and without delay. The block also keeps a separate set of enable bits for each CPU. From the incoming lines and those bits it produces one wakeup request per CPU, so that a CPU in a low-power state can be brought back when one of its enabled lines goes high.

Software programs the enable bits through a simple 32-bit word interface. A write strobe, a byte address and write data update a register on the rising clock edge. Read data follows the address combinationally. Each CPU's bank is a group of consecutive word registers, and the banks sit at a fixed address stride. Incoming lines are level-sensitive and asynchronous, so they pass through a two-flop synchroniser before the per-CPU wakeup reduction.

Top module: `wkup_gen`

## Requirements
- R1: Every bit of `irq_o` equals the same bit of `irq_i` at all times, whatever the enable bits hold.
- R2: While reset is low, and immediately after it, every enable register reads 0 and `wake_o` is 0.
- R3: CPU c (0 or 1) owns four enable registers. Register k (0..3) sits at byte address c*0x400 + 4*k. Line L is controlled by register L>>5, bit L%32, and bit value 1 means enabled.
- R4: A mapped enable register reads back exactly the last value written to it.
- R5: Every other address reads 0, and a write to it changes no enable register. This covers any address with bits [1:0] nonzero, bank offsets 0x10 to 0x3FC, and addresses at 0x800 and above.
- R6: With the enable bits steady, a change in the level of `irq_i` shows on `wake_o` at the third rising clock edge after the edge at which the new level is first presented.
- R7: An enable write captured at one rising edge shows on `wake_o` at the next rising edge. `wake_o[c]` is low whenever no enabled line of CPU c is high.
- R8: `wake_o[c]` is the OR over all 128 lines of (synchronised line AND CPU c's enable bit). A line enabled only for one CPU never raises the other CPU's request.
- R9: Writing 0xFFFFFFFF to a register enables all 32 of its lines for wakeup, and writing 0x00000000 masks all of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | 128 | Level-sensitive shared peripheral interrupt lines |
| irq_o | output | 128 | Unchanged copy of the lines, to the distributor |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Register byte address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for `addr_i` |
| wake_o | output | 2 | Wakeup request, one bit per CPU |

## Verification
The hardest cases to reach are the ones where timing interacts. One is an enable write that lands while a line is still moving through the synchroniser. The other is a line that is enabled for one CPU but whose register index and bit position belong to the other bank. Directed sequences hold a single line high, count edges one at a time to pin the three-edge latency, and then flip the enable to check the one-edge response. Random phases write sparse patterns into both banks and drive sparse line patterns. Each pattern is held long enough to settle before both requests are compared with a model of the bits. Unmapped addresses (misaligned, beyond the fourth register, and beyond the second bank) are written and then every mapped register is read back.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned WORD_LSB = 5;  // log2(WORD_W)
endpackage

// File: rtl/wkup_sync.sv
module wkup_sync #(
  parameter int unsigned WIDTH = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/wkup_regs.sv
module wkup_regs
  import wkup_pkg::*;
#(
  parameter int unsigned NUM_LINES  = 128,
  parameter int unsigned NUM_CPUS   = 2,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned CPU_STRIDE = 'h400
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               wr_en_i,
  input  logic [ADDR_W-1:0]                  addr_i,
  input  logic [WORD_W-1:0]                  wdata_i,
  output logic [WORD_W-1:0]                  rdata_o,
  output logic                               hit_o,
  output logic [NUM_CPUS-1:0][NUM_LINES-1:0] en_o
);
  localparam int unsigned REGS      = NUM_LINES / WORD_W;
  localparam int unsigned REG_W     = (REGS > 1) ? $clog2(REGS) : 1;
  localparam int unsigned CPU_W     = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1;
  localparam int unsigned BANK_SPAN = REGS * 4;

  logic [ADDR_W-1:0] cpu_sel, bank_off;
  logic [CPU_W-1:0]  cpu_idx;
  logic [REG_W-1:0]  reg_idx;

  assign cpu_sel  = addr_i / ADDR_W'(CPU_STRIDE);
  assign bank_off = addr_i % ADDR_W'(CPU_STRIDE);
  assign cpu_idx  = cpu_sel[CPU_W-1:0];
  assign reg_idx  = bank_off[REG_W+1:2];
  assign hit_o    = (cpu_sel < ADDR_W'(NUM_CPUS)) && (bank_off[1:0] == 2'b00)
                    && (bank_off < ADDR_W'(BANK_SPAN));

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    for (genvar r = 0; r < REGS; r++) begin : g_reg
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) word_q <= '0;
        else if (wr_en_i && hit_o && cpu_idx == CPU_W'(c) && reg_idx == REG_W'(r))
          word_q <= wdata_i;
      end
      assign en_o[c][r*WORD_W +: WORD_W] = word_q;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_o) rdata_o = en_o[cpu_idx][{reg_idx, WORD_LSB'(0)} +: WORD_W];
  end
endmodule

// File: rtl/wkup_reduce.sv
module wkup_reduce #(
  parameter int unsigned NUM_LINES = 128,
  parameter int unsigned NUM_CPUS  = 2
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [NUM_LINES-1:0]               irq_s_i,
  input  logic [NUM_CPUS-1:0][NUM_LINES-1:0] en_i,
  output logic [NUM_CPUS-1:0]                wake_o
);
  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic wake_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) wake_q <= 1'b0;
      else         wake_q <= |(irq_s_i & en_i[c]);
    end
    assign wake_o[c] = wake_q;
  end
endmodule

// File: rtl/wkup_gen.sv
module wkup_gen
  import wkup_pkg::*;
#(
  parameter int unsigned NUM_LINES  = 128,
  parameter int unsigned NUM_CPUS   = 2,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned CPU_STRIDE = 'h400
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_i,
  output logic [NUM_LINES-1:0] irq_o,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [WORD_W-1:0]    wdata_i,
  output logic [WORD_W-1:0]    rdata_o,
  output logic [NUM_CPUS-1:0]  wake_o
);
  logic [NUM_LINES-1:0]               irq_sync;
  logic [NUM_CPUS-1:0][NUM_LINES-1:0] en_bits;
  logic                               reg_hit;

  assign irq_o = irq_i;

  wkup_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(irq_i), .q_o(irq_sync)
  );

  wkup_regs #(
    .NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS),
    .ADDR_W(ADDR_W), .CPU_STRIDE(CPU_STRIDE)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .hit_o(reg_hit), .en_o(en_bits)
  );

  wkup_reduce #(.NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS)) u_reduce (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_s_i(irq_sync), .en_i(en_bits), .wake_o(wake_o)
  );
endmodule

// File: rtl/wkup_gen_chk.sv
module wkup_gen_chk #(
  parameter int unsigned NUM_LINES = 128,
  parameter int unsigned NUM_CPUS  = 2,
  parameter int unsigned ADDR_W    = 12
) (
  input logic                               clk_i,
  input logic                               rst_ni,
  input logic [NUM_LINES-1:0]               irq_s,
  input logic [NUM_CPUS-1:0][NUM_LINES-1:0] en,
  input logic                               hit,
  input logic                               wr_en_i,
  input logic [ADDR_W-1:0]                  addr_i,
  input logic [31:0]                        wdata_i,
  input logic [31:0]                        rdata_o,
  input logic [NUM_CPUS-1:0]                wake_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) a_r2_reset_clear : assert (wake_o == '0 && en == '0);
  end

  a_r4_readback : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && hit) |=> ((addr_i != $past(addr_i)) || (rdata_o == $past(wdata_i))));

  a_r5_unmapped_write_ignored : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !hit) |=> $stable(en));

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    a_r8_enabled_line_wakes : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(irq_s & en[c])) |=> wake_o[c]);
    a_r7_masked_quiet : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en[c] == '0) |=> !wake_o[c]);
  end
endmodule

bind wkup_gen wkup_gen_chk #(
  .NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_s(irq_sync), .en(en_bits), .hit(reg_hit),
  .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .wake_o(wake_o)
);

// File: tb/wkup_gen_bench.sv
`timescale 1ns/1ps
module wkup_gen_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [127:0] irq_i = '0;
  logic [127:0] irq_o;
  logic         wr_en_i = 1'b0;
  logic [11:0]  addr_i = '0;
  logic [31:0]  wdata_i = '0;
  logic [31:0]  rdata_o;
  logic [1:0]   wake_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [1:0][127:0] en_m = '0;

  always #4 clk_i = ~clk_i;

  wkup_gen u_wkup_gen (.*);

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      #1;
    end
  endtask

  function automatic logic [11:0] reg_addr(input int c, input int k);
    return 12'(c * 'h400 + k * 4);
  endfunction

  function automatic logic [1:0] exp_wake(input logic [127:0] lines);
    logic [1:0] w;
    for (int c = 0; c < 2; c++) w[c] = |(lines & en_m[c]);
    return w;
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    tick();
    wr_en_i = 1'b0;
    if (a[1:0] == 0 && a < 12'h800 && a[9:0] < 10'h10)
      en_m[a[10]][a[3:2]*32 +: 32] = d;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    addr_i = a;
    #1;
    chk(rdata_o === exp, tag, 128'(rdata_o), 128'(exp));
  endtask

  task automatic all_regs_chk(input string tag);
    for (int c = 0; c < 2; c++)
      for (int k = 0; k < 4; k++)
        rd_chk(reg_addr(c, k), en_m[c][k*32 +: 32], tag);
  endtask

  function automatic logic [127:0] rnd128(input bit sparse);
    logic [127:0] v;
    for (int i = 0; i < 4; i++) begin
      v[i*32 +: 32] = $urandom();
      if (sparse) v[i*32 +: 32] &= $urandom() & $urandom() & $urandom();
    end
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    tick(3);
    // R2: reset state
    chk(wake_o === 2'b00, "R2 wake in reset", 128'(wake_o), 128'(0));
    all_regs_chk("R2 regs in reset");
    rst_ni = 1'b1;
    tick();
    chk(wake_o === 2'b00, "R2 wake after reset", 128'(wake_o), 128'(0));

    // R1: pass-through with masked enables
    for (int i = 0; i < 4; i++) begin
      irq_i = rnd128(0);
      #1;
      chk(irq_o === irq_i, "R1 pass-through masked", irq_o, irq_i);
      tick();
    end
    tick(3);
    chk(wake_o === 2'b00, "R7 no enable no wake", 128'(wake_o), 128'(0));
    irq_i = '0;
    tick(3);

    // R6: three-edge latency on line 3 for CPU0
    wr(reg_addr(0, 0), 32'h0000_0008);
    irq_i[3] = 1'b1;
    tick();
    chk(wake_o === 2'b00, "R6 edge1 still low", 128'(wake_o), 128'(0));
    tick();
    chk(wake_o === 2'b00, "R6 edge2 still low", 128'(wake_o), 128'(0));
    tick();
    chk(wake_o === 2'b01, "R6 edge3 high", 128'(wake_o), 128'(1));
    irq_i[3] = 1'b0;
    tick(2);
    chk(wake_o === 2'b01, "R6 fall edge2 still high", 128'(wake_o), 128'(1));
    tick();
    chk(wake_o === 2'b00, "R6 fall edge3 low", 128'(wake_o), 128'(0));

    // R7: enable change takes one edge
    irq_i[3] = 1'b1;
    tick(3);
    wr(reg_addr(0, 0), 32'h0);
    chk(wake_o === 2'b01, "R7 write edge old value", 128'(wake_o), 128'(1));
    tick();
    chk(wake_o === 2'b00, "R7 masked after next edge", 128'(wake_o), 128'(0));
    irq_i = '0;

    // R3/R8: line 69 -> CPU1 reg 2 bit 5 only
    wr(reg_addr(1, 2), 32'h0000_0020);
    irq_i[69] = 1'b1;
    tick(3);
    chk(wake_o === 2'b10, "R3 R8 line 69 wakes cpu1 only", 128'(wake_o), 128'(2));
    irq_i[69] = 1'b0; irq_i[68] = 1'b1;
    tick(3);
    chk(wake_o === 2'b00, "R3 neighbour bit 68 quiet", 128'(wake_o), 128'(0));
    irq_i = '0;
    wr(reg_addr(1, 2), 32'h0);

    // R9: all ones / all zero on CPU0 reg 1
    wr(reg_addr(0, 1), 32'hFFFF_FFFF);
    rd_chk(reg_addr(0, 1), 32'hFFFF_FFFF, "R9 all-ones readback");
    irq_i[40] = 1'b1;
    tick(3);
    chk(wake_o === 2'b01, "R9 all-ones wakes line 40", 128'(wake_o), 128'(1));
    irq_i = '0; irq_i[63] = 1'b1;
    tick(3);
    chk(wake_o === 2'b01, "R9 all-ones wakes line 63", 128'(wake_o), 128'(1));
    wr(reg_addr(0, 1), 32'h0);
    tick();
    chk(wake_o === 2'b00, "R9 all-zero masks", 128'(wake_o), 128'(0));
    irq_i = '0;

    // R4: readback of random patterns in every register
    for (int c = 0; c < 2; c++)
      for (int k = 0; k < 4; k++)
        wr(reg_addr(c, k), $urandom());
    all_regs_chk("R4 readback");

    // R5: unmapped addresses
    begin
      logic [11:0] bad_addrs [6] = '{12'h010, 12'h002, 12'h3FC, 12'h40D, 12'h800, 12'hC04};
      for (int i = 0; i < 6; i++) begin
        wr(bad_addrs[i], 32'hA5A5_5A5A);
        rd_chk(bad_addrs[i], 32'h0, "R5 unmapped reads zero");
      end
      all_regs_chk("R5 mapped unchanged after unmapped writes");
    end

    // R8/R1: random sparse enables and lines
    for (int it = 0; it < 60; it++) begin
      logic [127:0] v;
      if ($urandom_range(0, 1) == 1)
        wr(reg_addr($urandom_range(0, 1), $urandom_range(0, 3)),
           $urandom() & $urandom() & $urandom());
      v = rnd128(1);
      irq_i = v;
      #1;
      chk(irq_o === v, "R1 pass-through random", irq_o, v);
      tick(3);
      chk(wake_o === exp_wake(v), "R8 random wake", 128'(wake_o), 128'(exp_wake(v)));
    end
    rd_chk(reg_addr(1, 3), en_m[1][96 +: 32], "R4 readback after random");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule